// File: doc/BRIEF.md
# Timed Reference Pulse Sequencer

This block pairs a free-running period timer with a small state machine that walks downstream divider channels through a fixed bring-up sequence and then emits a gated reference pulse burst. The timer period is a 12-bit programmed number of input clock cycles. A request moves the machine out of idle on the next timer boundary. It then passes through disable, reset, enable and start, and each step lasts one timer period. The machine then runs the pulse stream until the burst is complete or a stop arrives.

The pulse stream is timed in timer periods, not in divider output periods. Each pulse is high for one timer period and low for one timer period. The burst length comes from a 3-bit mode code, and some codes select an endless stream. The stream begins a fixed number of input clock cycles after the start step is entered. It is cut off combinationally from the state register, so a stop can leave a runt pulse. A configuration check compares the programmed phase offset with the runt-safe limit. While the check fails, the check output is high, pending requests are held back and the pulse output stays low.

Top module: `ref_pulse_seq`

## Requirements
- R1: The effective timer period P equals tmr_period_i in input clock cycles, and a value of 0 selects P = 4096. Each of the disable, reset and enable steps stays active for exactly P cycles.
- R2: After a request, the step outputs assert in the order div_dis_o, div_rst_o, div_en_o, div_start_o. Each step hands over directly to the next, and at most one step output is high at a time.
- R3: A request on req_i is taken only while busy_o is low. The disable step begins within P+1 cycles of the request. A request made while busy_o is high has no effect.
- R4: pulse_o first rises exactly 3 input clock cycles after div_start_o rises.
- R5: Each pulse is high for P cycles. Consecutive pulses are separated by P low cycles.
- R6: pulse_mode_i codes 0, 1, 2, 3 and 4 give bursts of 1, 2, 4, 8 and 16 pulses. busy_o falls in the same cycle as the falling edge of the last pulse.
- R7: pulse_mode_i codes 5, 6 and 7 select continuous mode, and pulses repeat until stop_i is asserted.
- R8: When stop_i is high in a clock cycle while busy_o is high, busy_o and pulse_o are both low in the following cycle, even in the middle of a pulse. A request still pending at that time is dropped.
- R9: cfg_err_o is high exactly when phase_ofs_i + 8 > floor(P/2). While it is high, pulse_o is low and a pending request does not start. Once it clears, the pending request proceeds.
- R10: During and just after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_period_i | input | 12 | Timer period in input clock cycles, 0 selects 4096 |
| phase_ofs_i | input | 12 | Programmed channel phase offset in input clock cycles |
| pulse_mode_i | input | 3 | Burst length code: 0..4 select 1..16 pulses, 5..7 select continuous |
| req_i | input | 1 | Sequence request |
| stop_i | input | 1 | Abort sequence or stream |
| div_dis_o | output | 1 | Disable step active |
| div_rst_o | output | 1 | Reset step active |
| div_en_o | output | 1 | Enable step active |
| div_start_o | output | 1 | Start step active |
| pulse_o | output | 1 | Gated pulse stream |
| busy_o | output | 1 | Sequence or stream in progress |
| cfg_err_o | output | 1 | Phase offset exceeds runt-safe limit |

## Verification
The hardest condition to reach is a stop that lands in the middle of a high pulse of a long continuous stream. That case shows the combinational cut-off and the resulting runt. The bench reaches it by running mode 6 through twenty full pulses, which is more than the longest finite burst. It then counts five cycles into the next high phase and raises stop_i. The 4096-cycle period and a request held back by a failing offset check are both driven directly from the ports. Each case is timed by counting samples between output edges.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DIS, ST_RST, ST_ENA, ST_START, ST_RUN
  } rps_state_e;

  // returns {continuous, index of last pulse}
  function automatic logic [4:0] decode_mode(input logic [2:0] m);
    case (m)
      3'd0:    decode_mode = 5'b0_0000;
      3'd1:    decode_mode = 5'b0_0001;
      3'd2:    decode_mode = 5'b0_0011;
      3'd3:    decode_mode = 5'b0_0111;
      3'd4:    decode_mode = 5'b0_1111;
      default: decode_mode = 5'b1_1111;
    endcase
  endfunction
endpackage

// File: rtl/rps_timer.sv
module rps_timer #(
  parameter int TMR_W = 12,
  localparam int PER_W = TMR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [TMR_W-1:0] cnt_q;
  logic [PER_W-1:0] per_m1;

  assign per_m1 = period_i - PER_W'(1);
  assign tick_o = PER_W'(cnt_q) >= per_m1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + TMR_W'(1);
  end

  p_wrap_after_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);
endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
  import rps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic       stop_i,
  input  logic       cfg_ok_i,
  input  logic       gen_done_i,
  output rps_state_e state_o,
  output logic       start_evt_o
);
  rps_state_e state_q, state_d;
  logic       pend_q;
  logic       in_step;

  assign in_step = (state_q == ST_DIS) || (state_q == ST_RST) ||
                   (state_q == ST_ENA) || (state_q == ST_START);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (pend_q && tick_i && cfg_ok_i) state_d = ST_DIS;
      ST_DIS:   if (tick_i) state_d = ST_RST;
      ST_RST:   if (tick_i) state_d = ST_ENA;
      ST_ENA:   if (tick_i) state_d = ST_START;
      ST_START: if (tick_i) state_d = ST_RUN;
      ST_RUN:   if (gen_done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (stop_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (stop_i || state_d != ST_IDLE) pend_q <= 1'b0;
      else if (req_i && state_q == ST_IDLE) pend_q <= 1'b1;
    end
  end

  assign state_o     = state_q;
  assign start_evt_o = (state_q == ST_ENA) && tick_i && !stop_i;

  p_step_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_step) && state_q != $past(state_q)) |-> $past(tick_i || stop_i));
  p_hold_on_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !cfg_ok_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/rps_pulse_gen.sv
module rps_pulse_gen #(
  parameter int TMR_W     = 12,
  parameter int START_LAT = 3,
  localparam int PER_W = TMR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_evt_i,
  input  logic             gate_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [3:0]       last_idx_i,
  input  logic             cont_i,
  output logic             level_o,
  output logic             done_o
);
  logic             launch;
  logic             gen_on_q, level_q;
  logic [TMR_W-1:0] cnt_q;
  logic [3:0]       idx_q;
  logic             wrap;

  generate
    if (START_LAT == 0) begin : g_nodly
      assign launch = start_evt_i;
    end else begin : g_dly
      logic [START_LAT-1:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else begin
          sh_q[0] <= start_evt_i;
          for (int i = 1; i < START_LAT; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign launch = sh_q[START_LAT-1];
    end
  endgenerate

  assign wrap   = PER_W'(cnt_q) >= (period_i - PER_W'(1));
  assign done_o = gen_on_q && level_q && wrap && idx_q == last_idx_i && !cont_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_on_q <= 1'b0;
      level_q  <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
    end else if (!gate_i) begin
      gen_on_q <= 1'b0;
      level_q  <= 1'b0;
    end else if (launch) begin
      gen_on_q <= 1'b1;
      level_q  <= 1'b1;
      cnt_q    <= '0;
      idx_q    <= '0;
    end else if (gen_on_q) begin
      if (wrap) begin
        cnt_q <= '0;
        if (level_q) begin
          level_q <= 1'b0;
          idx_q   <= idx_q + 4'd1;
          if (done_o) gen_on_q <= 1'b0;
        end else begin
          level_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + TMR_W'(1);
      end
    end
  end

  assign level_o = gen_on_q & level_q;

  p_done_stops_gen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !gen_on_q);
endmodule

// File: rtl/ref_pulse_seq.sv
module ref_pulse_seq
  import rps_pkg::*;
#(
  parameter int TMR_W     = 12,
  parameter int OFS_W     = 12,
  parameter int START_LAT = 3,
  localparam int PER_W = TMR_W + 1,
  localparam int CMP_W = ((OFS_W > PER_W) ? OFS_W : PER_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] tmr_period_i,
  input  logic [OFS_W-1:0] phase_ofs_i,
  input  logic [2:0]       pulse_mode_i,
  input  logic             req_i,
  input  logic             stop_i,
  output logic             div_dis_o,
  output logic             div_rst_o,
  output logic             div_en_o,
  output logic             div_start_o,
  output logic             pulse_o,
  output logic             busy_o,
  output logic             cfg_err_o
);
  logic [PER_W-1:0] period;
  logic             tick, start_evt, gen_done, gen_level, gate;
  logic [4:0]       mode_dec;
  rps_state_e       state;

  assign period = (tmr_period_i == '0) ? {1'b1, {TMR_W{1'b0}}} : {1'b0, tmr_period_i};

  // runt-safe limit: offset must not exceed P/2 - 8
  assign cfg_err_o = (CMP_W'(phase_ofs_i) + CMP_W'(8)) > CMP_W'(period >> 1);
  assign mode_dec  = decode_mode(pulse_mode_i);

  rps_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .period_i(period), .tick_o(tick)
  );

  rps_fsm u_fsm (
    .clk_i, .rst_ni, .tick_i(tick), .req_i, .stop_i,
    .cfg_ok_i(!cfg_err_o), .gen_done_i(gen_done),
    .state_o(state), .start_evt_o(start_evt)
  );

  assign gate = (state == ST_START) || (state == ST_RUN);

  rps_pulse_gen #(.TMR_W(TMR_W), .START_LAT(START_LAT)) u_pgen (
    .clk_i, .rst_ni, .start_evt_i(start_evt), .gate_i(gate),
    .period_i(period), .last_idx_i(mode_dec[3:0]), .cont_i(mode_dec[4]),
    .level_o(gen_level), .done_o(gen_done)
  );

  // combinational cut-off from the state register
  assign pulse_o     = gen_level & gate & !cfg_err_o;
  assign busy_o      = state != ST_IDLE;
  assign div_dis_o   = state == ST_DIS;
  assign div_rst_o   = state == ST_RST;
  assign div_en_o    = state == ST_ENA;
  assign div_start_o = state == ST_START;

  p_stop_cuts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> (!pulse_o && !busy_o));
  p_err_silences_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !pulse_o);
  p_pulse_in_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> busy_o);
endmodule

// File: tb/ref_pulse_seq_tb.sv
module ref_pulse_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] tmr = 12'd16;
  logic [11:0] ofs = 12'd0;
  logic [2:0]  mode = 3'd0;
  logic        req = 1'b0;
  logic        stop = 1'b0;
  logic        dis, rst_s, en, start, pulse, busy, err;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  ref_pulse_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tmr_period_i(tmr), .phase_ofs_i(ofs),
    .pulse_mode_i(mode), .req_i(req), .stop_i(stop),
    .div_dis_o(dis), .div_rst_o(rst_s), .div_en_o(en), .div_start_o(start),
    .pulse_o(pulse), .busy_o(busy), .cfg_err_o(err)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic t_reset();
    chk({dis, rst_s, en, start, pulse, busy} == 6'b0, "R10 outputs in reset",
        int'({dis, rst_s, en, start, pulse, busy}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({dis, rst_s, en, start, pulse, busy} == 6'b0, "R10 outputs after reset",
        int'({dis, rst_s, en, start, pulse, busy}), 0);
  endtask

  // full sequence and burst, p = expected period
  task automatic t_seq(input logic [11:0] t, input logic [2:0] m, input int p, input int n_exp);
    int w, n, s, h, l, cnt, multi;
    tmr = t; mode = m; ofs = 12'd0;
    pulse_req();
    w = 1; multi = 0;
    while (!dis) begin @(negedge clk); w++; end
    chk(w <= p + 1, "R3 start latency", w, p + 1);
    n = 0;
    while (dis) begin
      if (int'(dis) + int'(rst_s) + int'(en) + int'(start) > 1) multi++;
      n++; @(negedge clk);
    end
    chk(n == p, "R1 disable length", n, p);
    chk(rst_s, "R2 reset follows disable", int'(rst_s), 1);
    n = 0;
    while (rst_s) begin n++; @(negedge clk); end
    chk(n == p, "R1 reset length", n, p);
    chk(en, "R2 enable follows reset", int'(en), 1);
    n = 0;
    while (en) begin
      if (int'(dis) + int'(rst_s) + int'(en) + int'(start) > 1) multi++;
      n++; @(negedge clk);
    end
    chk(n == p, "R1 enable length", n, p);
    chk(start && multi == 0, "R2 start follows enable, one step at a time", multi, 0);
    s = 0;
    while (!pulse) begin s++; @(negedge clk); end
    chk(s == 3, "R4 pulse latency after start", s, 3);
    cnt = 0;
    forever begin
      h = 0;
      while (pulse) begin h++; @(negedge clk); end
      cnt++;
      chk(h == p, "R5 pulse high length", h, p);
      if (cnt >= n_exp) begin
        chk(!busy, "R6 busy drops with last pulse", int'(busy), 0);
        break;
      end
      chk(busy, "R6 burst continues", int'(busy), 1);
      l = 0;
      while (!pulse && busy) begin l++; @(negedge clk); end
      chk(l == p, "R5 pulse low length", l, p);
      if (!busy) break;
    end
    chk(cnt == n_exp, "R6 pulse count", cnt, n_exp);
  endtask

  task automatic t_cont_stop();
    int h, l, bad;
    tmr = 12'd20; mode = 3'd6; ofs = 12'd0;
    pulse_req();
    while (!pulse) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      h = 0;
      while (pulse) begin h++; @(negedge clk); end
      l = 0;
      while (!pulse && busy) begin l++; @(negedge clk); end
      if (h != 20 || l != 20) bad++;
    end
    chk(bad == 0 && busy, "R7 continuous stream beyond 16 pulses", bad, 0);
    repeat (5) @(negedge clk);
    chk(pulse, "R8 stream high before stop", int'(pulse), 1);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(!pulse && !busy, "R8 stop cuts pulse", int'({pulse, busy}), 0);
  endtask

  task automatic t_stop_early();
    int seen;
    tmr = 12'd16; mode = 3'd0; ofs = 12'd0;
    pulse_req();
    while (!dis) @(negedge clk);
    repeat (2) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(!busy && !dis, "R8 stop during disable", int'({busy, dis}), 0);
    seen = 0;
    repeat (48) begin @(negedge clk); if (busy || pulse) seen++; end
    chk(seen == 0, "R8 no restart after stop", seen, 0);
  endtask

  task automatic t_busy_ignore();
    int seen;
    tmr = 12'd16; mode = 3'd0; ofs = 12'd0;
    pulse_req();
    while (!pulse) @(negedge clk);
    pulse_req();
    while (busy) @(negedge clk);
    seen = 0;
    repeat (60) begin @(negedge clk); if (busy) seen++; end
    chk(seen == 0, "R3 request while busy ignored", seen, 0);
  endtask

  task automatic t_cfg();
    int seen, w;
    tmr = 12'd40; ofs = 12'd12; @(negedge clk);
    chk(!err, "R9 offset at limit", int'(err), 0);
    ofs = 12'd13; @(negedge clk);
    chk(err, "R9 offset over limit", int'(err), 1);
    tmr = 12'd15; ofs = 12'd0; @(negedge clk);
    chk(err, "R9 short period always flagged", int'(err), 1);
    tmr = 12'd0; ofs = 12'd2040; @(negedge clk);
    chk(!err, "R9 max period limit", int'(err), 0);
    ofs = 12'd2041; @(negedge clk);
    chk(err, "R9 max period over limit", int'(err), 1);
    tmr = 12'd40; ofs = 12'd13; mode = 3'd0;
    pulse_req();
    seen = 0;
    repeat (150) begin @(negedge clk); if (busy || pulse) seen++; end
    chk(seen == 0, "R9 request held while flagged", seen, 0);
    ofs = 12'd0;
    w = 0;
    while (!busy && w < 100) begin @(negedge clk); w++; end
    chk(busy && w <= 41, "R9 pending request proceeds", w, 41);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_seq(12'd16, 3'd0, 16, 1);
    t_seq(12'd16, 3'd1, 16, 2);
    t_seq(12'd16, 3'd2, 16, 4);
    t_seq(12'd16, 3'd3, 16, 8);
    t_seq(12'd16, 3'd4, 16, 16);
    t_seq(12'd33, 3'd1, 33, 2);
    t_seq(12'd0,  3'd0, 4096, 1);
    t_cont_stop();
    t_stop_early();
    t_busy_ignore();
    t_cfg();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule